// File: doc/BRIEF.md
# Registered Asynchronous SRAM Controller

This block connects a synchronous core bus to an external asynchronous static RAM with a 16-bit data path. The core hands over one read or one write at a time. The block then drives the memory's address lines, data lines, chip select, read strobe and write strobe. Every pin it drives comes directly from a flip-flop, so a glitch in decode logic cannot reach the board.

A write takes three phases. In the first phase the address and data are placed on the pins. In the second phase the write strobe is pulled low for one cycle. In the third phase the strobe is released while the address and data stay where they are. Because of this, the strobe never moves on the same clock edge as the address or data bus.

A read places the address on the pins and lowers the read strobe. One cycle later the block samples the data lines into a register. The core then sees a one-cycle response pulse. Requests use a valid/ready handshake. The block raises ready only when it is idle, so a request offered while a transaction runs is not taken and leaves no trace. The response side has no back-pressure: the core must accept the response pulse in the cycle it appears.

Top module: `regsram_bridge`

## Requirements
- R1: While reset is held and right after it: `sram_we_n`, `sram_oe_n` and `sram_ce_n` are 1, `sram_dq_oe` is 0, `busy` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: On the clock edge that accepts a write, `sram_addr` takes the request address and `sram_dq_out` takes the write data, `sram_dq_oe` goes to 1 and `sram_ce_n` goes to 0. `sram_we_n` stays 1 on that edge and falls on the next edge.
- R3: `sram_we_n` is low for exactly one clock cycle per write.
- R4: On the edge where `sram_we_n` returns high, `sram_addr`, `sram_dq_out` and `sram_dq_oe` do not change. On the following edge, `sram_dq_oe` drops to 0 and `sram_ce_n` rises to 1.
- R5: `sram_we_n` never changes on the same clock edge as `sram_addr` or `sram_dq_out`.
- R6: On the edge that accepts a read, `sram_addr` takes the request address and both `sram_ce_n` and `sram_oe_n` go to 0. `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R7: One cycle after a read is accepted, `sram_dq_in` is captured into `rsp_rdata`. On that same edge `rsp_valid` rises for exactly one cycle, and `sram_oe_n` and `sram_ce_n` return to 1.
- R8: `busy` is 1 and `req_ready` is 0 for three cycles after a write is accepted and for one cycle after a read is accepted. A request offered while `busy` is 1 is not accepted and does not change any pin.
- R9: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_write` = 1 selects a write and `req_write` = 0 selects a read.
- R10: `rsp_rdata` keeps its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 16 | Captured read data |
| sram_addr | output | 18 | Registered memory address |
| sram_dq_out | output | 16 | Registered write data to the pad |
| sram_dq_oe | output | 1 | Data pad driver enable, active high |
| sram_dq_in | input | 16 | Data from the pad |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Read strobe, active low |
| sram_we_n | output | 1 | Write strobe, active low |

## Verification
The assertions assume that the core obeys the handshake: it offers a request only through `req_valid`, and nothing besides the block itself moves the memory pins. They also assume that `sram_dq_in` settles before the capture edge.

The bench plays the memory. It returns stored words combinationally from the registered address whenever both strobes are low. It drives every core input on the falling clock edge, and it leaves a request up only until the edge that accepts it. The exception is deliberate pokes into busy cycles, which test that such requests are ignored.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int SRB_AW = 18;
  localparam int SRB_DW = 16;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_W_SETUP  = 3'd1,
    PH_W_STROBE = 3'd2,
    PH_W_HOLD   = 3'd3,
    PH_R_WAIT   = 3'd4
  } phase_t;
endpackage

// File: rtl/srb_sequencer.sv
module srb_sequencer
  import srb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output phase_t phase,
  output logic   accept,
  output logic   busy,
  output logic   ready
);
  phase_t phase_nx;

  assign ready  = (phase == PH_IDLE);
  assign busy   = ~ready;
  assign accept = req_valid & ready;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:     if (accept) phase_nx = req_write ? PH_W_SETUP : PH_R_WAIT;
      PH_W_SETUP:  phase_nx = PH_W_STROBE;
      PH_W_STROBE: phase_nx = PH_W_HOLD;
      PH_W_HOLD:   phase_nx = PH_IDLE;
      PH_R_WAIT:   phase_nx = PH_IDLE;
      default:     phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/srb_pin_bank.sv
module srb_pin_bank
  import srb_pkg::*;
#(
  parameter int AW = SRB_AW,
  parameter int DW = SRB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] pin_addr,
  output logic [DW-1:0] pin_dq,
  output logic          pin_dq_oe,
  output logic          pin_ce_n,
  output logic          pin_oe_n,
  output logic          pin_we_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_addr  <= '0;
      pin_dq    <= '0;
      pin_dq_oe <= 1'b0;
      pin_ce_n  <= 1'b1;
      pin_oe_n  <= 1'b1;
      pin_we_n  <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            pin_addr <= req_addr;
            pin_ce_n <= 1'b0;
            if (req_write) begin
              pin_dq    <= req_wdata;
              pin_dq_oe <= 1'b1;
            end else begin
              pin_oe_n  <= 1'b0;
            end
          end
        end
        PH_W_SETUP:  pin_we_n <= 1'b0;
        PH_W_STROBE: pin_we_n <= 1'b1;
        PH_W_HOLD: begin
          pin_dq_oe <= 1'b0;
          pin_ce_n  <= 1'b1;
        end
        PH_R_WAIT: begin
          pin_oe_n <= 1'b1;
          pin_ce_n <= 1'b1;
        end
        default: begin
          pin_we_n  <= 1'b1;
          pin_oe_n  <= 1'b1;
          pin_dq_oe <= 1'b0;
          pin_ce_n  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/srb_read_capture.sv
module srb_read_capture #(
  parameter int DW = srb_pkg::SRB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= sample;
      if (sample) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/regsram_bridge.sv
module regsram_bridge
  import srb_pkg::*;
#(
  parameter int AW = SRB_AW,
  parameter int DW = SRB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n
);
  phase_t phase;
  logic   accept;

  srb_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .phase(phase), .accept(accept), .busy(busy), .ready(req_ready)
  );

  srb_pin_bank #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .accept(accept),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .pin_addr(sram_addr), .pin_dq(sram_dq_out), .pin_dq_oe(sram_dq_oe),
    .pin_ce_n(sram_ce_n), .pin_oe_n(sram_oe_n), .pin_we_n(sram_we_n)
  );

  srb_read_capture #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .sample(phase == PH_R_WAIT),
    .dq_in(sram_dq_in), .rdata(rsp_rdata), .rvalid(rsp_valid)
  );
endmodule

module regsram_bridge_chk #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rsp_valid,
  input logic [AW-1:0] sram_addr,
  input logic [DW-1:0] sram_dq_out,
  input logic          sram_dq_oe,
  input logic          sram_oe_n,
  input logic          sram_we_n
);
  a_r2_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(sram_dq_oe) && sram_dq_oe);
  a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n);
  a_r4_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out));
  a_r5_no_joint_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sram_we_n) |-> $stable(sram_addr) && $stable(sram_dq_out));
  a_r6_no_drive_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r8_busy_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sram_addr));
endmodule

bind regsram_bridge regsram_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
  .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
);

// File: tb/regsram_bridge_test.sv
module regsram_bridge_test;
  localparam int AW = 18;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, busy, rsp_valid;
  logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;
  logic sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;

  always #4 clk = ~clk;

  regsram_bridge #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n)
  );

  // memory behind the pins
  logic [DW-1:0] smem [256];
  logic [DW-1:0] mmem [256];
  initial begin
    for (int i = 0; i < 256; i++) begin
      smem[i] = 16'h1357 ^ DW'(i * 259);
      mmem[i] = 16'h1357 ^ DW'(i * 259);
    end
  end
  assign sram_dq_in = (!sram_oe_n && !sram_ce_n) ? smem[sram_addr[7:0]] : 16'hBAD0;
  always @(posedge sram_we_n) if (!sram_ce_n && sram_dq_oe) smem[sram_addr[7:0]] = sram_dq_out;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on every rising edge
  int ph = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_dq = '0, e_rd = '0;
  logic e_oe_drv = 0, e_ce = 1, e_oe = 1, e_we = 1, e_rv = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; e_addr = '0; e_dq = '0; e_rd = '0;
      e_oe_drv = 0; e_ce = 1; e_oe = 1; e_we = 1; e_rv = 0;
    end else begin
      e_rv = 0;
      case (ph)
        0: if (req_valid) begin
             e_addr = req_addr; e_ce = 0;
             if (req_write) begin e_dq = req_wdata; e_oe_drv = 1; ph = 1; end
             else begin e_oe = 0; ph = 10; end
           end
        1: begin e_we = 0; ph = 2; end
        2: begin e_we = 1; mmem[e_addr[7:0]] = e_dq; ph = 3; end
        3: begin e_oe_drv = 0; e_ce = 1; ph = 0; end
        10: begin e_rd = mmem[e_addr[7:0]]; e_rv = 1; e_oe = 1; e_ce = 1; ph = 0; end
        default: ph = 0;
      endcase
    end
  end

  logic p_we = 1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;
  always @(negedge clk) if (rst_n) begin
    chk(sram_addr == e_addr && sram_dq_out == e_dq, (ph == 0 || ph == 3) ? "R4 addr/data" : "R2 addr/data",
        {sram_addr[15:0], sram_dq_out}, {e_addr[15:0], e_dq});
    chk(sram_we_n == e_we, "R3 we_n", 32'(sram_we_n), 32'(e_we));
    chk(sram_dq_oe == e_oe_drv && sram_ce_n == e_ce && sram_oe_n == e_oe, "R6 dq_oe/ce_n/oe_n",
        {sram_dq_oe, sram_ce_n, sram_oe_n}, {e_oe_drv, e_ce, e_oe});
    chk(rsp_valid == e_rv && rsp_rdata == e_rd, e_rv ? "R7 response" : "R10 rdata hold",
        {15'd0, rsp_valid, rsp_rdata}, {15'd0, e_rv, e_rd});
    chk(busy == (ph != 0) && req_ready == (ph == 0), ph == 0 ? "R9 ready" : "R8 busy",
        {busy, req_ready}, {ph != 0, ph == 0});
    if (sram_we_n != p_we)
      chk(sram_addr == p_addr && sram_dq_out == p_dq, "R5 we_n moved with bus",
          {sram_addr[15:0], sram_dq_out}, {p_addr[15:0], p_dq});
    p_we = sram_we_n; p_addr = sram_addr; p_dq = sram_dq_out;
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic poke_busy(input logic [AW-1:0] held);
    req_valid = 1; req_write = 1; req_addr = ~held; req_wdata = 16'hEEEE;
    @(negedge clk);
    req_valid = 0;
    chk(sram_addr == held, "R8 request during busy ignored", 32'(sram_addr), 32'(held));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  bit done = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sram_we_n && sram_oe_n && sram_ce_n && !sram_dq_oe && !busy && req_ready && !rsp_valid,
        "R1 reset state", {sram_we_n, sram_oe_n, sram_ce_n, sram_dq_oe, busy, req_ready, rsp_valid},
        7'b1110010);
    rst_n = 1;
    @(negedge clk);
    chk(sram_we_n && sram_ce_n && req_ready, "R1 after release", {sram_we_n, sram_ce_n, req_ready}, 3'b111);

    do_req(1, 18'h00010, 16'hA5A5);
    poke_busy(18'h00010);
    idle(4);
    do_req(0, 18'h00010, 16'h0);
    poke_busy(18'h00010);
    idle(3);
    // boundary addresses and data patterns
    do_req(1, 18'h00000, 16'h0000);
    do_req(1, 18'h3FFFF, 16'hFFFF);
    do_req(0, 18'h3FFFF, 16'h0);
    do_req(0, 18'h00000, 16'h0);
    for (int i = 0; i < 12; i++) do_req(1, AW'(i * 37 + 3), DW'(16'h9E37 * (i + 1)));
    for (int i = 11; i >= 0; i--) do_req(0, AW'(i * 37 + 3), 16'h0);
    do_req(0, 18'h00080, 16'h0);   // never written
    idle(6);                       // R10: response data held while idle
    // requests held high: back-to-back acceptance
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 18'h00055; req_wdata = 16'h3C3C;
    repeat (8) @(negedge clk);
    req_write = 0;
    repeat (4) @(negedge clk);
    req_valid = 0;
    idle(6);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule